// File: doc/BRIEF.md
# Eye Scan Sweep Controller

This controller runs a two-dimensional eye and error-contour scan for a serial receiver. It walks a grid of sampling points: a 5-bit phase-interpolator code that sets the measurement sampler's delay from the recovered clock, and a 6-bit threshold-voltage code that sets that sampler's decision level. At each grid point it compares the measurement sampler's bit with the bit from the live recovered-data sampler. Every disagreement counts as an error, so no known test pattern is needed.

A scan starts on a one-cycle start pulse and visits all 2,048 points. The voltage code moves fastest and the phase code slowest. At each point the controller first waits a programmable number of cycles so the analog path can settle. It then counts mismatches over a programmable dwell of 2^N valid bits. Finally it writes the point's error count into a result memory, which a processor reads afterwards. The counter stops at its all-ones value rather than wrapping. A one-cycle done pulse marks the end of the scan.

Top module: `eye_scan_ctrl`

## Requirements
- R1: After reset, busy, done and mem_we are low, and phase_code and volt_code are zero.
- R2: A scan writes the 2,048 pixels in a fixed order. The voltage code is the inner loop and the phase code the outer loop, starting from 0/0. Each write goes to mem_addr = {phase_code, volt_code}, with phase in address bits 10:6 and voltage in bits 5:0. phase_code and volt_code show the pixel being measured.
- R3: A pixel's stored count is the number of counted bits where meas_bit differs from data_bit. The dwell for each pixel is 2^dwell_log2 counted bits.
- R4: A cycle with bit_valid low is not counted. It neither adds an error nor advances the dwell, whatever the sampled bits are.
- R5: The per-pixel count saturates at 2^CNT_W-1 and never wraps.
- R6: At the start of each pixel, the first settle_cycles+1 clock cycles after the new codes appear are not counted.
- R7: done is high for exactly one cycle: the cycle right after the write of address 2047. busy is low from the next cycle on.
- R8: A start pulse while busy is ignored. dwell_log2 and settle_cycles are captured at start, and later changes to them have no effect on the running scan.
- R9: mem_we is a single-cycle pulse, once per pixel, for exactly 2,048 writes per scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle scan start pulse |
| dwell_log2 | input | 5 | Dwell length as log2 of counted bits |
| settle_cycles | input | 8 | Settle wait after each code change |
| meas_bit | input | 1 | Bit from the measurement sampler |
| data_bit | input | 1 | Bit from the nominal data sampler |
| bit_valid | input | 1 | Both sampled bits are valid this cycle |
| phase_code | output | 5 | Phase-interpolator code |
| volt_code | output | 6 | Threshold-voltage code |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished pulse |
| mem_we | output | 1 | Result memory write enable |
| mem_addr | output | 11 | Result memory address {phase, voltage} |
| mem_wdata | output | CNT_W | Pixel error count |

## Verification
The bench gives each pixel one of four stimulus classes, chosen from its own codes. The classes are: no mismatches, mismatches on every valid bit, mismatches with randomly gated valid, and mismatches only on invalid bits. Together they separate correct error counting from counting on ignored cycles. During each settle window the bench drives forced mismatches, so a controller that starts counting too early shows up as a non-zero count on a clean pixel. Three scans use different dwell and settle values. One of them has a dwell longer than the count range, which exercises saturation. Another injects a start pulse and changes the dwell and settle inputs halfway through, to prove the configuration is captured at start.

// File: rtl/eye_scan_pkg.sv
package eye_scan_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETTLE = 3'd1,
      ST_COUNT  = 3'd2,
      ST_WRITE  = 3'd3,
      ST_DONE   = 3'd4
   } scan_state_t;

endpackage

// File: rtl/eye_scan_errcnt.sv
module eye_scan_errcnt #(
   parameter int CNT_W    = 16,
   parameter int BIT_W    = 32,
   parameter int DLW      = 5,
   parameter bit INV_MEAS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic [DLW-1:0]   dlog,
   input  logic             meas_bit,
   input  logic             data_bit,
   input  logic             bit_valid,
   output logic             dwell_hit,
   output logic [CNT_W-1:0] err_q
);

   localparam logic [CNT_W-1:0] ERR_MAX = {CNT_W{1'b1}};

   logic             mism;
   logic [BIT_W-1:0] bcnt_q;
   logic [BIT_W-1:0] dwell_mask;

   // Sampler polarity option: an inverted measurement path flips the sense
   generate
      if (INV_MEAS) begin : g_inv
         assign mism = ~(meas_bit ^ data_bit);
      end else begin : g_dir
         assign mism = meas_bit ^ data_bit;
      end
   endgenerate

   assign dwell_mask = (BIT_W'(1) << dlog) - BIT_W'(1);
   assign dwell_hit  = count_en && bit_valid && (bcnt_q == dwell_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt_q <= '0;
         err_q  <= '0;
      end else if (!count_en) begin
         bcnt_q <= '0;
         err_q  <= '0;
      end else if (bit_valid) begin
         bcnt_q <= bcnt_q + BIT_W'(1);
         if (mism && (err_q != ERR_MAX)) begin
            err_q <= err_q + CNT_W'(1);
         end
      end
   end

   AST_ERR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && bit_valid && mism && (err_q == ERR_MAX)) |=> (err_q == ERR_MAX)); // R5

   AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && !bit_valid) |=> ($stable(err_q) && $stable(bcnt_q))); // R4

endmodule

// File: rtl/eye_scan_seq.sv
module eye_scan_seq
   import eye_scan_pkg::*;
#(
   parameter int PH_W  = 5,
   parameter int VT_W  = 6,
   parameter int DLW   = 5,
   parameter int SET_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DLW-1:0]   dlog_in,
   input  logic [SET_W-1:0] settle_in,
   input  logic             dwell_hit,
   output logic             count_en,
   output logic             busy,
   output logic             done,
   output logic             mem_we,
   output logic [PH_W-1:0]  phase,
   output logic [VT_W-1:0]  volt,
   output logic [DLW-1:0]   dlog_q
);

   scan_state_t      st_q, st_d;
   logic [SET_W-1:0] settle_q;
   logic [SET_W-1:0] scnt_q;
   logic             last_px;

   assign last_px  = (phase == {PH_W{1'b1}}) && (volt == {VT_W{1'b1}});
   assign count_en = (st_q == ST_COUNT);
   assign busy     = (st_q != ST_IDLE);
   assign done     = (st_q == ST_DONE);
   assign mem_we   = (st_q == ST_WRITE);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (start) st_d = ST_SETTLE;
         ST_SETTLE: if (scnt_q == settle_q) st_d = ST_COUNT;
         ST_COUNT:  if (dwell_hit) st_d = ST_WRITE;
         ST_WRITE:  st_d = last_px ? ST_DONE : ST_SETTLE;
         ST_DONE:   st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         phase    <= '0;
         volt     <= '0;
         settle_q <= '0;
         dlog_q   <= '0;
         scnt_q   <= '0;
      end else begin
         st_q <= st_d;
         if ((st_q == ST_IDLE) && start) begin
            phase    <= '0;
            volt     <= '0;
            settle_q <= settle_in;
            dlog_q   <= dlog_in;
         end
         if (st_q == ST_SETTLE) scnt_q <= scnt_q + SET_W'(1);
         else                   scnt_q <= '0;
         if ((st_q == ST_WRITE) && !last_px) begin
            volt <= volt + VT_W'(1);
            if (volt == {VT_W{1'b1}}) phase <= phase + PH_W'(1);
         end
      end
   end

   AST_VOLT_INNER: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_WRITE) && !last_px && (volt != {VT_W{1'b1}}))
      |=> ((volt == VT_W'($past(volt) + 1'b1)) && (phase == $past(phase)))); // R2

   AST_PHASE_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_WRITE) && !last_px && (volt == {VT_W{1'b1}}))
      |=> ((volt == '0) && (phase == PH_W'($past(phase) + 1'b1)))); // R2

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(mem_we) && $past(last_px))); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy)); // R7

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(settle_q) && $stable(dlog_q))); // R8

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && !done) |=> busy); // R8

   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we); // R9

endmodule

// File: rtl/eye_scan_ctrl.sv
module eye_scan_ctrl #(
   parameter int PH_W     = 5,
   parameter int VT_W     = 6,
   parameter int CNT_W    = 16,
   parameter int BIT_W    = 32,
   parameter int SET_W    = 8,
   parameter bit INV_MEAS = 1'b0,
   localparam int DLW     = $clog2(BIT_W),
   localparam int ADDR_W  = PH_W + VT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DLW-1:0]    dwell_log2,
   input  logic [SET_W-1:0]  settle_cycles,
   input  logic              meas_bit,
   input  logic              data_bit,
   input  logic              bit_valid,
   output logic [PH_W-1:0]   phase_code,
   output logic [VT_W-1:0]   volt_code,
   output logic              busy,
   output logic              done,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [CNT_W-1:0]  mem_wdata
);

   // Elaboration-time parameter checks
   generate
      if (PH_W < 1 || VT_W < 1) begin : g_bad_axis
         $error("eye_scan_ctrl: axis code widths must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("eye_scan_ctrl: CNT_W must be at least 1");
      end
      if (BIT_W < 2 || (BIT_W & (BIT_W - 1)) != 0) begin : g_bad_bitw
         $error("eye_scan_ctrl: BIT_W must be a power of two of at least 2");
      end
      if (SET_W < 1) begin : g_bad_set
         $error("eye_scan_ctrl: SET_W must be at least 1");
      end
   endgenerate

   logic           count_en;
   logic           dwell_hit;
   logic [DLW-1:0] dlog_q;

   eye_scan_seq #(
      .PH_W  (PH_W),
      .VT_W  (VT_W),
      .DLW   (DLW),
      .SET_W (SET_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .dlog_in   (dwell_log2),
      .settle_in (settle_cycles),
      .dwell_hit (dwell_hit),
      .count_en  (count_en),
      .busy      (busy),
      .done      (done),
      .mem_we    (mem_we),
      .phase     (phase_code),
      .volt      (volt_code),
      .dlog_q    (dlog_q)
   );

   eye_scan_errcnt #(
      .CNT_W    (CNT_W),
      .BIT_W    (BIT_W),
      .DLW      (DLW),
      .INV_MEAS (INV_MEAS)
   ) u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_en  (count_en),
      .dlog      (dlog_q),
      .meas_bit  (meas_bit),
      .data_bit  (data_bit),
      .bit_valid (bit_valid),
      .dwell_hit (dwell_hit),
      .err_q     (mem_wdata)
   );

   assign mem_addr = {phase_code, volt_code};

   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy); // R9

endmodule

// File: tb/eye_scan_ctrl_tb.sv
module eye_scan_ctrl_tb;

   localparam int PH_W  = 5;
   localparam int VT_W  = 6;
   localparam int CNT_W = 5;
   localparam int BIT_W = 32;
   localparam int SET_W = 8;
   localparam int DLW   = 5;
   localparam int NPIX  = 2048;
   localparam int SAT   = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [DLW-1:0]   dwell_log2 = '0;
   logic [SET_W-1:0] settle_cycles = '0;
   logic             meas_bit = 1'b0;
   logic             data_bit = 1'b0;
   logic             bit_valid = 1'b0;
   logic [PH_W-1:0]  phase_code;
   logic [VT_W-1:0]  volt_code;
   logic             busy, done, mem_we;
   logic [10:0]      mem_addr;
   logic [CNT_W-1:0] mem_wdata;

   eye_scan_ctrl #(
      .PH_W (PH_W), .VT_W (VT_W), .CNT_W (CNT_W), .BIT_W (BIT_W), .SET_W (SET_W)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .start (start), .dwell_log2 (dwell_log2),
      .settle_cycles (settle_cycles), .meas_bit (meas_bit), .data_bit (data_bit),
      .bit_valid (bit_valid), .phase_code (phase_code), .volt_code (volt_code),
      .busy (busy), .done (done), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata)
   );

   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 195000) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 195000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   int  cur_dlog, cur_settle, scan_id;
   int  g = 0;
   int  idx = 0;
   int  done_cnt = 0;
   bit  fresh = 1'b0;
   bit  prev_we = 1'b0;
   bit  prev_last = 1'b0;

   function automatic int pix_class(int p, int v, int sid);
      return (p * 5 + v * 3 + sid) % 4;
   endfunction

   function automatic int exp_count(int p, int v, int sid, int dlog);
      int c;
      int d;
      c = pix_class(p, v, sid);
      d = 1 << dlog;
      if (c == 1 || c == 2) return (d > SAT) ? SAT : d;
      return 0;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      int  c, p, v, e;
      bit  mm;
      string req;
      @(negedge clk);
      if (fresh) begin
         g = cur_settle;
         fresh = 1'b0;
      end
      // monitor
      if (done) begin
         check(prev_last, "R7 done follows last write", int'(prev_last), 1);
         done_cnt++;
      end
      if (mem_we) begin
         check(!prev_we, "R9 single-cycle write", int'(prev_we), 0);
         check(int'(mem_addr) == idx, "R2 write order", int'(mem_addr), idx);
         check({phase_code, volt_code} == mem_addr, "R2 codes match address",
               int'({phase_code, volt_code}), int'(mem_addr));
         p = int'(mem_addr) >> 6;
         v = int'(mem_addr) & 63;
         e = exp_count(p, v, scan_id, cur_dlog);
         c = pix_class(p, v, scan_id);
         if (c == 0)              req = "R6 clean pixel after settle";
         else if (c == 3)         req = "R4 invalid bits ignored";
         else if (e == SAT && (1 << cur_dlog) > SAT) req = "R5 saturation";
         else if (c == 2)         req = "R4 gated valid count";
         else                     req = "R3 mismatch count";
         if (scan_id == 0) req = {req, " / R8 latched dwell"};
         check(int'(mem_wdata) == e, req, int'(mem_wdata), e);
         idx++;
         if (int'(mem_addr) != NPIX - 1) fresh = 1'b1;
      end
      prev_we   = mem_we;
      prev_last = mem_we && (int'(mem_addr) == NPIX - 1);
      // drive
      c = pix_class(int'(phase_code), int'(volt_code), scan_id);
      if (g > 0) begin
         g--;
         bit_valid = 1'b1;
         mm = 1'b1;
      end else begin
         case (c)
            0: begin bit_valid = 1'b1; mm = 1'b0; end
            1: begin bit_valid = 1'b1; mm = 1'b1; end
            2: begin bit_valid = 1'($urandom_range(0, 1)); mm = 1'b1; end
            default: begin bit_valid = 1'($urandom_range(0, 1)); mm = !bit_valid; end
         endcase
      end
      data_bit = 1'($urandom_range(0, 1));
      meas_bit = data_bit ^ mm;
   endtask

   task automatic run_scan(int dlog, int settle, int sid, bit poke);
      bit poked;
      poked = 1'b0;
      cur_dlog = dlog;
      cur_settle = settle;
      scan_id = sid;
      idx = 0;
      done_cnt = 0;
      dwell_log2 = DLW'(dlog);
      settle_cycles = SET_W'(settle);
      step();
      start = 1'b1;
      fresh = 1'b1;
      step();
      start = 1'b0;
      check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
      while (done_cnt == 0) begin
         step();
         if (poke && !poked && idx == 1000) begin
            start = 1'b1;
            dwell_log2 = DLW'(dlog ^ 3);
            settle_cycles = SET_W'(settle + 5);
            poked = 1'b1;
         end else begin
            start = 1'b0;
         end
      end
      check(idx == NPIX, "R9 write count per scan", idx, NPIX);
      step();
      check(!busy && !done, "R7 done one cycle then idle",
            int'({busy, done}), 0);
      check(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
   endtask

   initial begin
      void'($urandom(32'h5EED_E7E5));
      repeat (3) @(negedge clk);
      check(!busy && !done && !mem_we, "R1 reset control outputs",
            int'({busy, done, mem_we}), 0);
      check(phase_code == '0 && volt_code == '0, "R1 reset codes",
            int'({phase_code, volt_code}), 0);
      rst_n = 1'b1;
      step();
      check(!busy && !mem_we, "R1 idle after reset", int'({busy, mem_we}), 0);
      run_scan(2, 3, 0, 1'b1);
      run_scan(5, 0, 1, 1'b0);
      run_scan(0, 1, 2, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule